// File: doc/BRIEF.md
# Circular Buffer DMA Write Address Controller

This block hands out write addresses for a stream of fixed 128-byte transfers that fill a circular memory region. Software programs a region base, a region end, a limit address and an interrupt threshold through a small word-indexed register port. A downstream memory-write engine sees one outstanding request at a time: the block raises `xfer_req` with the target address and holds it until `xfer_ack` reports that the transfer has completed. On that acknowledge the write pointer advances by one transfer and wraps back to the base when it reaches the end.

The limit address gives back-pressure from the consumer. The writer never starts a transfer at the limit address, and it waits until software moves the limit further on. A limit of all ones never matches, so the writer runs without pause. An interrupt becomes pending when the pointer lands on the programmed threshold while the interrupt is armed. The `irq` output stays high while the interrupt is pending and armed.

Top module: `cbw_ring_writer`

## Requirements
- R1: After reset `xfer_req` and `irq` are low, the pointer reads 0 and the status word reads 0.
- R2: While the writer is running and idle and the pointer differs from the limit, `xfer_req` rises on the next clock with `xfer_addr` equal to the pointer. An acknowledge of that request adds 128 to the pointer.
- R3: When pointer + 128 reaches or passes the end address, the acknowledge loads the base address into the pointer instead.
- R4: No transfer is started while the pointer equals the limit address, and the status stalled bit is then set. After the limit moves, the request is issued. A limit of 0xFFFFFFFF never blocks.
- R5: Writing to word 5 is decoded by value: 2 loads the base address into the pointer and stops the writer, 1 starts the writer, and 0 stops it. Any other value has no effect.
- R6: A stop while a request is outstanding leaves that request up until it is acknowledged. The acknowledge still advances the pointer, and no further request follows.
- R7: A write of 2 to word 5 while a request is outstanding is ignored entirely. The pointer and the running state are unchanged.
- R8: The interrupt becomes pending when an acknowledge or an init moves the pointer onto the threshold address (word 3) while armed. `irq` is high while pending and armed, and it holds at that level until it is cleared.
- R9: In word 6, bit 0 arms the interrupt and bit 1 clears the pending flag. Writing 3 arms it from a clean state, and writing 2 disarms and clears it. While disarmed, landing on the threshold sets nothing. Reading word 6 returns the arm bit in bit 0.
- R10: When an interrupt-control write and a threshold hit fall in the same cycle, the arm value being written decides the outcome. With 3 the flag ends pending, and with 2 it ends clear.
- R11: An acknowledge with no request outstanding is ignored. While a request waits, `xfer_addr` holds steady.
- R12: The register words are as follows: 0 base, 1 end, 2 limit and 3 threshold, all read/write; 4 pointer, read-only; 5 DMA control; 6 interrupt control. Word 7 is status with bit0 running, bit1 busy, bit2 stalled, bit3 pending and bit4 armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| xfer_req | output | 1 | Transfer request outstanding |
| xfer_addr | output | 32 | Byte address of the requested transfer |
| xfer_ack | input | 1 | Transfer completed |
| irq | output | 1 | Threshold interrupt, level high |

## Verification
The interrupt-control write and the pointer landing on the threshold can fall in the same clock. In that case the clear and the arm decision compete with the new pending event. The bench provokes this by raising `xfer_ack` for the request one transfer short of the threshold in the same cycle that it writes word 6, once with the value 3 and once with the value 2. It then judges the outcome from `irq` and from status bit 3 on the following cycle: pending with 3, clear with 2.

// File: rtl/cbw_pkg.sv
package cbw_pkg;
  localparam int unsigned ADDR_W = 32;
  typedef logic [ADDR_W-1:0] addr_t;

  typedef enum logic [2:0] {
    RG_BASE   = 3'd0,
    RG_END    = 3'd1,
    RG_LIMIT  = 3'd2,
    RG_THRESH = 3'd3,
    RG_PTR    = 3'd4,
    RG_CTRL   = 3'd5,
    RG_ICTRL  = 3'd6,
    RG_STAT   = 3'd7
  } reg_idx_e;

  typedef struct packed {
    logic armed;
    logic pend;
    logic stalled;
    logic busy;
    logic run;
  } stat_t;

  // Pointer after one completed transfer, wrapping at the region end.
  function automatic addr_t ring_next(input addr_t p, input addr_t step,
                                     input addr_t lo, input addr_t hi);
    logic [ADDR_W:0] s;
    s = {1'b0, p} + {1'b0, step};
    return (s >= {1'b0, hi}) ? lo : s[ADDR_W-1:0];
  endfunction
endpackage

// File: rtl/cbw_regs.sv
module cbw_regs
  import cbw_pkg::*;
#(
  parameter int unsigned RA_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [RA_W-1:0] addr,
  input  addr_t           wdata,
  output addr_t           base_q,
  output addr_t           end_q,
  output addr_t           limit_q,
  output addr_t           thresh_q,
  output logic            cmd_init,
  output logic            cmd_run,
  output logic            cmd_stop,
  output logic            ictl_wr,
  output logic            ictl_arm,
  output logic            ictl_clr
);
  localparam addr_t CODE_STOP = addr_t'(0);
  localparam addr_t CODE_RUN  = addr_t'(1);
  localparam addr_t CODE_INIT = addr_t'(2);

  logic ctrl_wr;

  always_comb begin
    ctrl_wr  = we && (addr == RA_W'(RG_CTRL));
    cmd_init = ctrl_wr && (wdata == CODE_INIT);
    cmd_run  = ctrl_wr && (wdata == CODE_RUN);
    cmd_stop = ctrl_wr && (wdata == CODE_STOP);
    ictl_wr  = we && (addr == RA_W'(RG_ICTRL));
    ictl_arm = wdata[0];
    ictl_clr = wdata[1];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q   <= '0;
      end_q    <= '0;
      limit_q  <= '0;
      thresh_q <= '0;
    end else if (we) begin
      case (addr)
        RA_W'(RG_BASE):   base_q   <= wdata;
        RA_W'(RG_END):    end_q    <= wdata;
        RA_W'(RG_LIMIT):  limit_q  <= wdata;
        RA_W'(RG_THRESH): thresh_q <= wdata;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/cbw_ptr.sv
module cbw_ptr
  import cbw_pkg::*;
#(
  parameter int unsigned XFER_BYTES = 128
) (
  input  logic  clk,
  input  logic  rst_n,
  input  addr_t base_a,
  input  addr_t end_a,
  input  addr_t limit_a,
  input  logic  cmd_init,
  input  logic  cmd_run,
  input  logic  cmd_stop,
  input  logic  ack,
  output addr_t ptr_q,
  output logic  run_q,
  output logic  busy_q,
  output logic  stalled,
  output logic  upd,
  output addr_t upd_val
);
  localparam addr_t STEP = addr_t'(XFER_BYTES);

  logic at_limit, issue, done, init_ok;

  always_comb begin
    at_limit = (ptr_q == limit_a);
    done     = busy_q && ack;
    init_ok  = cmd_init && !busy_q;
    issue    = run_q && !busy_q && !at_limit && !cmd_init && !cmd_stop;
    stalled  = run_q && !busy_q && at_limit;
    upd      = done || init_ok;
    upd_val  = init_ok ? base_a : ring_next(ptr_q, STEP, base_a, end_a);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      run_q  <= 1'b0;
      busy_q <= 1'b0;
    end else begin
      if (upd) ptr_q <= upd_val;
      if (init_ok) run_q <= 1'b0;
      else if (cmd_stop) run_q <= 1'b0;
      else if (cmd_run) run_q <= 1'b1;
      if (done) busy_q <= 1'b0;
      else if (issue) busy_q <= 1'b1;
    end
  end
endmodule

// File: rtl/cbw_irq.sv
module cbw_irq
  import cbw_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  ictl_wr,
  input  logic  ictl_arm,
  input  logic  ictl_clr,
  input  logic  upd,
  input  addr_t upd_val,
  input  addr_t thresh,
  output logic  arm_q,
  output logic  pend_q,
  output logic  hit,
  output logic  irq
);
  logic arm_nx, pend_nx;

  always_comb begin
    hit    = upd && (upd_val == thresh);
    arm_nx = ictl_wr ? ictl_arm : arm_q;
    if (hit && arm_nx)           pend_nx = 1'b1;
    else if (ictl_wr && ictl_clr) pend_nx = 1'b0;
    else                          pend_nx = pend_q;
    irq    = pend_q && arm_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      arm_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      arm_q  <= arm_nx;
      pend_q <= pend_nx;
    end
  end
endmodule

// File: rtl/cbw_ring_writer.sv
module cbw_ring_writer
  import cbw_pkg::*;
#(
  parameter int unsigned RA_W       = 3,
  parameter int unsigned XFER_BYTES = 128
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_we,
  input  logic [RA_W-1:0] reg_addr,
  input  logic [31:0]     reg_wdata,
  output logic [31:0]     reg_rdata,
  output logic            xfer_req,
  output logic [31:0]     xfer_addr,
  input  logic            xfer_ack,
  output logic            irq
);
  addr_t base_q, end_q, limit_q, thresh_q, ptr_q, upd_val;
  logic  cmd_init, cmd_run, cmd_stop, ictl_wr, ictl_arm, ictl_clr;
  logic  run_q, busy_q, stalled, upd, arm_q, pend_q, hit;
  stat_t stat;

  cbw_regs #(.RA_W(RA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .base_q(base_q), .end_q(end_q), .limit_q(limit_q), .thresh_q(thresh_q),
    .cmd_init(cmd_init), .cmd_run(cmd_run), .cmd_stop(cmd_stop),
    .ictl_wr(ictl_wr), .ictl_arm(ictl_arm), .ictl_clr(ictl_clr)
  );

  cbw_ptr #(.XFER_BYTES(XFER_BYTES)) u_ptr (
    .clk(clk), .rst_n(rst_n), .base_a(base_q), .end_a(end_q), .limit_a(limit_q),
    .cmd_init(cmd_init), .cmd_run(cmd_run), .cmd_stop(cmd_stop), .ack(xfer_ack),
    .ptr_q(ptr_q), .run_q(run_q), .busy_q(busy_q), .stalled(stalled),
    .upd(upd), .upd_val(upd_val)
  );

  cbw_irq u_irq (
    .clk(clk), .rst_n(rst_n), .ictl_wr(ictl_wr), .ictl_arm(ictl_arm),
    .ictl_clr(ictl_clr), .upd(upd), .upd_val(upd_val), .thresh(thresh_q),
    .arm_q(arm_q), .pend_q(pend_q), .hit(hit), .irq(irq)
  );

  always_comb begin
    stat.armed   = arm_q;
    stat.pend    = pend_q;
    stat.stalled = stalled;
    stat.busy    = busy_q;
    stat.run     = run_q;
    xfer_req     = busy_q;
    xfer_addr    = ptr_q;
    case (reg_addr)
      RA_W'(RG_BASE):   reg_rdata = base_q;
      RA_W'(RG_END):    reg_rdata = end_q;
      RA_W'(RG_LIMIT):  reg_rdata = limit_q;
      RA_W'(RG_THRESH): reg_rdata = thresh_q;
      RA_W'(RG_PTR):    reg_rdata = ptr_q;
      RA_W'(RG_ICTRL):  reg_rdata = {31'd0, arm_q};
      RA_W'(RG_STAT):   reg_rdata = {27'd0, stat};
      default:          reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/cbw_ring_writer_chk.sv
module cbw_ring_writer_chk #(
  parameter int unsigned XFER_BYTES = 128
) (
  input logic        clk,
  input logic        rst_n,
  input logic        xfer_req,
  input logic        xfer_ack,
  input logic [31:0] xfer_addr,
  input logic [31:0] ptr_q,
  input logic [31:0] base_q,
  input logic [31:0] limit_q,
  input logic [31:0] thresh_q,
  input logic        run_q,
  input logic        pend_q
);
  localparam logic [31:0] STEP = 32'(XFER_BYTES);

  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_req && !xfer_ack |=> xfer_req && $stable(xfer_addr)); // R11

  AST_STEP_OR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_req && xfer_ack |=> (ptr_q == $past(ptr_q) + STEP) || (ptr_q == $past(base_q))); // R3

  AST_NOT_AT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(xfer_req) |-> xfer_addr != $past(limit_q)); // R4

  AST_ISSUE_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(xfer_req) |-> $past(run_q)); // R5

  AST_PEND_AT_THRESH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_q) |-> ptr_q == $past(thresh_q)); // R8
endmodule

bind cbw_ring_writer cbw_ring_writer_chk #(.XFER_BYTES(XFER_BYTES)) u_chk (
  .clk(clk), .rst_n(rst_n), .xfer_req(xfer_req), .xfer_ack(xfer_ack),
  .xfer_addr(xfer_addr), .ptr_q(ptr_q), .base_q(base_q), .limit_q(limit_q),
  .thresh_q(thresh_q), .run_q(run_q), .pend_q(pend_q)
);

// File: tb/tb_cbw_ring_writer.sv
`timescale 1ns/1ps
module tb_cbw_ring_writer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        xfer_req;
  logic [31:0] xfer_addr;
  logic        xfer_ack = 1'b0;
  logic        irq;
  int checks = 0;
  int fails = 0;
  logic [31:0] v;

  always #2 clk = ~clk;

  cbw_ring_writer dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .xfer_req(xfer_req),
    .xfer_addr(xfer_addr), .xfer_ack(xfer_ack), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_req();
    for (int n = 0; n < 50 && !xfer_req; n++) @(negedge clk);
  endtask

  task automatic ack_one();
    wait_req();
    xfer_ack = 1'b1;
    @(negedge clk);
    xfer_ack = 1'b0;
  endtask

  // acknowledge together with an interrupt-control write in the same cycle
  task automatic ack_with_ictl(input logic [31:0] d);
    wait_req();
    xfer_ack = 1'b1; reg_we = 1'b1; reg_addr = 3'd6; reg_wdata = d;
    @(negedge clk);
    xfer_ack = 1'b0; reg_we = 1'b0;
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R1 req after reset", {31'd0, xfer_req}, 32'd0);
    chk("R1 irq after reset", {31'd0, irq}, 32'd0);
    rd(3'd4, v); chk("R1 pointer after reset", v, 32'd0);
    rd(3'd7, v); chk("R1 status after reset", v, 32'd0);
  endtask

  task automatic t_init_run();
    wr(3'd0, 32'h400); wr(3'd1, 32'h2400); wr(3'd2, 32'hFFFF_FFFF);
    rd(3'd0, v); chk("R12 base readback", v, 32'h400);
    rd(3'd1, v); chk("R12 end readback", v, 32'h2400);
    wr(3'd5, 32'd2);
    rd(3'd4, v); chk("R5 init loads base", v, 32'h400);
    chk("R5 init leaves stopped", {31'd0, xfer_req}, 32'd0);
    wr(3'd5, 32'd1);
    cycles(1);
    chk("R2 request raised", {31'd0, xfer_req}, 32'd1);
    chk("R2 request address", xfer_addr, 32'h400);
    ack_one();
    rd(3'd4, v); chk("R2 pointer step", v, 32'h480);
  endtask

  task automatic t_wrap();
    for (int i = 0; i < 62; i++) ack_one();
    wait_req();
    chk("R3 last address before wrap", xfer_addr, 32'h2380);
    ack_one();
    rd(3'd4, v); chk("R3 wrap to base", v, 32'h400);
  endtask

  task automatic t_limit();
    wr(3'd2, 32'h580);
    ack_one(); ack_one(); ack_one();
    cycles(5);
    chk("R4 no request at limit", {31'd0, xfer_req}, 32'd0);
    rd(3'd7, v); chk("R4 status stalled", v, 32'h5);
    wr(3'd2, 32'hFFFF_FFFF);
    cycles(1);
    chk("R4 resumes after limit moves", {xfer_req, xfer_addr[30:0]}, {1'b1, 31'h580});
  endtask

  task automatic t_stop();
    wr(3'd5, 32'd0);
    chk("R6 request held after stop", {31'd0, xfer_req}, 32'd1);
    ack_one();
    cycles(3);
    chk("R6 no new request", {31'd0, xfer_req}, 32'd0);
    rd(3'd4, v); chk("R6 pointer advanced", v, 32'h600);
    rd(3'd7, v); chk("R6 status idle", v, 32'd0);
    wr(3'd5, 32'd7);
    cycles(3);
    chk("R5 other code ignored", {31'd0, xfer_req}, 32'd0);
  endtask

  task automatic t_init_busy();
    wr(3'd5, 32'd1);
    cycles(1);
    chk("R7 request before init", xfer_addr, 32'h600);
    wr(3'd5, 32'd2);
    rd(3'd4, v); chk("R7 pointer kept", v, 32'h600);
    ack_one();
    cycles(1);
    chk("R7 still running", {xfer_req, xfer_addr[30:0]}, {1'b1, 31'h680});
  endtask

  task automatic t_irq();
    wr(3'd3, 32'h780); wr(3'd6, 32'd3);
    ack_one();
    chk("R8 no irq before threshold", {31'd0, irq}, 32'd0);
    ack_one();
    chk("R8 irq at threshold", {31'd0, irq}, 32'd1);
    cycles(3);
    chk("R8 irq level holds", {31'd0, irq}, 32'd1);
    rd(3'd7, v); chk("R8 status pending", (v >> 3) & 32'd1, 32'd1);
    wr(3'd6, 32'd3);
    chk("R9 clear drops irq", {31'd0, irq}, 32'd0);
    wr(3'd6, 32'd2); wr(3'd3, 32'h800);
    rd(3'd6, v); chk("R9 arm readback", v, 32'd0);
    ack_one();
    rd(3'd7, v); chk("R9 disarmed sets nothing", (v >> 3) & 32'd1, 32'd0);
  endtask

  task automatic t_same_cycle();
    wr(3'd3, 32'h880);
    ack_with_ictl(32'd3);
    chk("R10 arm+hit irq", {31'd0, irq}, 32'd1);
    rd(3'd7, v); chk("R10 arm+hit pending", (v >> 3) & 32'd1, 32'd1);
    wr(3'd3, 32'h900);
    ack_with_ictl(32'd2);
    chk("R10 disarm+hit irq", {31'd0, irq}, 32'd0);
    rd(3'd7, v); chk("R10 disarm+hit pending", (v >> 3) & 32'd1, 32'd0);
  endtask

  task automatic t_stray_ack();
    wr(3'd5, 32'd0);
    ack_one();
    cycles(2);
    xfer_ack = 1'b1;
    @(negedge clk);
    xfer_ack = 1'b0;
    rd(3'd4, v); chk("R11 stray ack ignored", v, 32'h980);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    t_reset();
    t_init_run();
    t_wrap();
    t_limit();
    t_stop();
    t_init_busy();
    t_irq();
    t_same_cycle();
    t_stray_ack();
    finish_run();
  end
endmodule